// File: doc/BRIEF.md
# Delayed Supply-Check Stimulus Sequencer

This block drives three stimulus enables for a supply-protection check. A 3-bit position code from a multi-position function selector names the supply under test. A test-start pulse launches a long fixed delay. The delay is counted in ticks of a slow timebase, not in clock cycles. When the delay runs out, the block asserts the one enable that the latched position names. The other two enables stay low, which stands for an open circuit on those lines.

The delay keeps the check from being applied right after power-up. With a 10 kHz tick, five seconds is 50,000 ticks, and that is the default. While the delay runs, a busy flag is high. If the selector is moved during the delay, or after the stimulus is applied, the block drops everything and returns to idle. A new start pulse is then needed.

Top module: `supply_stim_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes idle. After that edge, `busy_o` is 0 and `stim_o` is 3'b000.
- R2: A start pulse with a stimulus position (codes 1, 2, 3) raises `busy_o` with all enables low. The enable goes high on the edge that samples the DELAY_TICKS-th tick after the start, and not before. `busy_o` falls on that same edge.
- R3: At most one enable is high at any time. Code 1 drives `stim_o[0]`, code 2 drives `stim_o[1]`, and code 3 drives `stim_o[2]`. The two unselected bits stay 0.
- R4: Only clock cycles with `tick_i` high advance the delay. Any number of cycles without a tick leaves the remaining delay unchanged.
- R5: Code 0 (off) forces `stim_o` to 3'b000. A start pulse with code 0, or with codes 4 to 7, is ignored: `busy_o` stays 0 and no enable is raised.
- R6: If the position code differs from the latched code during the delay, the block returns to idle on the next edge. No enable is raised, however many further ticks arrive.
- R7: After the delay, the selected enable stays high until the position code changes. A change drops `stim_o` to 0 in the same cycle, and the block returns to idle. Restoring the code does not re-apply the stimulus without a new start.
- R8: Start pulses that arrive while the delay is running, or while a stimulus is applied, are ignored. They do not restart the delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse from the slow timebase |
| start_i | input | 1 | One-cycle test-start pulse |
| pos_i | input | 3 | Function selector position code |
| stim_o | output | 3 | Stimulus enables, at most one high |
| busy_o | output | 1 | High while the delay is being counted |

## Verification
The bench uses a short delay and checks the tick just before expiry and the tick on which expiry occurs. A counter that is off by one would show its enable one tick early or one tick late.

Clock cycles without ticks are inserted during the delay. A design that counts clock cycles instead of ticks would fire early.

Two cases cover selector moves. A move during the delay must cancel the stimulus for good. A move after the stimulus is applied must drop the enable in that same cycle; a design that only reacts on the next edge would leave a stray stimulus for one cycle.

Repeated start pulses are sent during the delay. A design that restarts its delay on them would fire late. All eight codes are swept, so a decoder that lights the wrong bit, or lights a bit for codes 0 or 4 to 7, is caught.

// File: rtl/sss_pkg.sv
// Package: shared constants and types for the supply-check stimulus sequencer.
// Assumes the selector always presents a 3-bit code and the three
// stimulus positions occupy consecutive codes starting at POS_FIRST_STIM.
package sss_pkg;

    localparam int unsigned POS_W     = 3;
    localparam int unsigned NUM_STIM  = 3;

    localparam logic [POS_W-1:0] POS_OFF        = 3'd0;
    localparam logic [POS_W-1:0] POS_FIRST_STIM = 3'd1;
    localparam logic [POS_W-1:0] POS_LAST_STIM  = POS_FIRST_STIM + POS_W'(NUM_STIM - 1);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_APPLY = 2'd2
    } seq_state_t;

    // True when a position code selects one of the stimulus outputs.
    function automatic logic is_stim_pos(input logic [POS_W-1:0] code);
        return (code >= POS_FIRST_STIM) && (code <= POS_LAST_STIM);
    endfunction

endpackage

// File: rtl/sss_tick_counter.sv
// Module: delay counter that advances only on timebase ticks.
// While run_i is high it counts ticks and pulses done_o on the tick that
// completes DELAY_TICKS ticks. A clear input or reset returns it to zero.
// Assumes DELAY_TICKS >= 1.
module sss_tick_counter #(
    parameter int unsigned DELAY_TICKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int unsigned   CW   = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks while running; wrap to zero on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Completion strobe on the final tick of the delay.
    always_comb begin
        done_o = run_i && tick_i && (cnt_q == LAST);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

    AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/sss_seq_ctrl.sv
// Module: control state machine for the sequencer.
// Latches the position on a valid start. It then waits for the counter's
// done strobe and holds the applied state. It drops to idle whenever the
// live code departs from the latched one. Start pulses outside idle are
// ignored.
module sss_seq_ctrl
    import sss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             done_i,
    output logic             cnt_clear_o,
    output logic             cnt_run_o,
    output logic             busy_o,
    output logic             apply_o,
    output logic [POS_W-1:0] held_o
);

    seq_state_t       state_q, state_d;
    logic [POS_W-1:0] held_q, held_d;
    logic             pos_moved;

    // Detect selector movement against the latched position.
    always_comb begin
        pos_moved = (pos_i != held_q);
    end

    // Next-state and latch decision.
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i && is_stim_pos(pos_i)) begin
                    state_d = SEQ_WAIT;
                    held_d  = pos_i;
                end
            end
            SEQ_WAIT: begin
                if (pos_moved)   state_d = SEQ_IDLE;
                else if (done_i) state_d = SEQ_APPLY;
            end
            SEQ_APPLY: begin
                if (pos_moved)   state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State and latched-position registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            held_q  <= POS_OFF;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Decoded controls for the counter and the output stage.
    always_comb begin
        cnt_run_o   = (state_q == SEQ_WAIT);
        cnt_clear_o = (state_q != SEQ_WAIT);
        busy_o      = (state_q == SEQ_WAIT);
        apply_o     = (state_q == SEQ_APPLY);
        held_o      = held_q;
    end

    AST_ABORT_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE && pos_i != held_q) |=> (state_q == SEQ_IDLE)); // R6

    AST_APPLY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && !done_i) |=> (state_q != SEQ_APPLY)); // R2

    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && pos_i == held_q && !done_i) |=>
            (state_q == SEQ_WAIT && $stable(held_q))); // R8

endmodule

// File: rtl/sss_out_decode.sv
// Module: output decoder for the stimulus enables.
// Raises the single enable that the latched position names, and only
// while the applied state holds and the live code still matches. So a
// selector move silences the outputs in the same cycle.
module sss_out_decode
    import sss_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply_i,
    input  logic [POS_W-1:0]    held_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic [NUM_STIM-1:0] stim_o
);

    logic still_selected;

    // Live code must still equal the latched code.
    always_comb begin
        still_selected = apply_i && (pos_i == held_i);
    end

    // One enable per stimulus position.
    for (genvar g = 0; g < NUM_STIM; g++) begin : g_stim
        always_comb begin
            stim_o[g] = still_selected && (held_i == POS_FIRST_STIM + POS_W'(g));
        end
    end

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stim_o)); // R3

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i == POS_OFF) |-> (stim_o == '0)); // R5

endmodule

// File: rtl/supply_stim_sequencer.sv
// Module: top of the delayed supply-check stimulus sequencer.
// A start pulse in a stimulus position arms a delay of DELAY_TICKS
// timebase ticks. After the delay, one of three mutually exclusive
// enables is raised. Assumes tick_i is a single-cycle pulse synchronous
// to clk, and that rst_n is synchronous and active low.
module supply_stim_sequencer
    import sss_pkg::*;
#(
    parameter int unsigned DELAY_TICKS = 50000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic [NUM_STIM-1:0] stim_o,
    output logic                busy_o
);

    logic             cnt_clear;
    logic             cnt_run;
    logic             cnt_done;
    logic             apply;
    logic [POS_W-1:0] held_pos;

    sss_tick_counter #(.DELAY_TICKS(DELAY_TICKS)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .run_i   (cnt_run),
        .tick_i  (tick_i),
        .done_o  (cnt_done)
    );

    sss_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pos_i       (pos_i),
        .done_i      (cnt_done),
        .cnt_clear_o (cnt_clear),
        .cnt_run_o   (cnt_run),
        .busy_o      (busy_o),
        .apply_o     (apply),
        .held_o      (held_pos)
    );

    sss_out_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply_i (apply),
        .held_i  (held_pos),
        .pos_i   (pos_i),
        .stim_o  (stim_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && stim_o == '0)); // R1

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && (stim_o != '0))); // R2

endmodule

// File: tb/tb_supply_stim_sequencer.sv
`timescale 1ns/1ps
// Bench: a vector sweep over all position codes, then directed corner cases.
module tb_supply_stim_sequencer;

    localparam int unsigned D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] pos_i = 3'd0;
    logic [2:0] stim_o;
    logic       busy_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    supply_stim_sequencer #(.DELAY_TICKS(D)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
        .pos_i(pos_i), .stim_o(stim_o), .busy_o(busy_o)
    );

    always #2.5 clk = ~clk;

    // {pos[2:0], busy while waiting, enable after delay[2:0]}
    localparam logic [6:0] VEC [8] = '{
        {3'd0, 1'b0, 3'b000},
        {3'd1, 1'b1, 3'b001},
        {3'd2, 1'b1, 3'b010},
        {3'd3, 1'b1, 3'b100},
        {3'd4, 1'b0, 3'b000},
        {3'd5, 1'b0, 3'b000},
        {3'd6, 1'b0, 3'b000},
        {3'd7, 1'b0, 3'b000}
    };

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if ({busy_o, stim_o} !== exp) begin
            bad++;
            $display("FAIL %s: {busy,stim} actual=%b expected=%b", req, {busy_o, stim_o}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; start_i = 1'b0; tick_i = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R1 reset state", 4'b0000);

        // Sweep every position code: R2, R3, R5.
        for (int v = 0; v < 8; v++) begin
            do_reset();
            pos_i = VEC[v][6:4];
            pulse_start();
            do_ticks(D - 1);
            check(VEC[v][3] ? "R2 before expiry" : "R5 start ignored", {VEC[v][3], 3'b000});
            do_ticks(1);
            check(VEC[v][3] ? "R3 enable at expiry" : "R5 no enable", {1'b0, VEC[v][2:0]});
        end

        // R4: cycles without ticks do not advance the delay.
        do_reset();
        pos_i = 3'd1;
        pulse_start();
        idle_cycles(3 * D);
        check("R4 no tick no progress", 4'b1000);
        do_ticks(D - 1);
        check("R4 one tick short", 4'b1000);
        do_ticks(1);
        check("R4 expiry on tick", 4'b0001);

        // R7: the enable is held, and a move drops it in the same cycle.
        idle_cycles(20);
        check("R7 held after delay", 4'b0001);
        @(negedge clk); pos_i = 3'd0; #1;
        check("R7 same-cycle drop", 4'b0000);
        @(negedge clk); pos_i = 3'd1;
        idle_cycles(2);
        check("R7 no re-apply without start", 4'b0000);

        // R1: reset while a stimulus is applied.
        pos_i = 3'd3;
        pulse_start();
        do_ticks(D);
        check("R2 applied pos3", 4'b0100);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset clears output", 4'b0000);

        // R6: a move mid-delay aborts for good.
        pos_i = 3'd2;
        pulse_start();
        do_ticks(3);
        @(negedge clk); pos_i = 3'd1;
        @(negedge clk);
        check("R6 abort to idle", 4'b0000);
        do_ticks(2 * D);
        check("R6 no later stimulus", 4'b0000);

        // R8: repeated starts do not restart the delay.
        do_reset();
        pos_i = 3'd2;
        pulse_start();
        do_ticks(4);
        pulse_start();
        do_ticks(D - 5);
        check("R8 still waiting", 4'b1000);
        do_ticks(1);
        check("R8 expiry not restarted", 4'b0010);
        pulse_start();
        do_ticks(2);
        check("R8 start during apply ignored", 4'b0010);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule